// File: doc/BRIEF.md
# Quarter-Symmetric Chopped Square-Wave Generator

This block drives one two-level inverter leg with a chopped square wave. The leg sits at either the positive rail (+E) or the negative rail (−E), each being half of the DC supply. Software works out a set of N switching angles offline for the first quarter of the fundamental and hands them in as a packed table. The block keeps a phase accumulator that advances by a programmable increment every clock. It compares the accumulated phase against the angles and produces the leg command together with a complementary pair of gate enables.

Only the N first-quarter angles are stored. The transitions in the second quarter come from reflecting each angle about π/2. The negative half-cycle is the inverse of the positive half, which gives 2N transitions in each half-cycle. The table is sampled only when the accumulator wraps into a new period, so the waveform never mixes two tables. Before the block accepts a table it checks that the angles are ordered and below π/2. A table that fails this check is replaced by a plain square wave, and an error flag is raised.

Top module: `she_pattern_gen`

## Requirements
- R1: While reset is asserted, and for the first clock edge after reset is released, `leg_o`, `gate_hi_o`, `gate_lo_o` and `err_o` are all 0.
- R2: The phase advances by `phase_inc_i` on every clock, modulo 2^PHASE_W, where 2^PHASE_W equals one full period of 2π. The registered outputs after a clock edge reflect the phase that was held before that edge.
- R3: Angles are in units of 2π/2^PHASE_W. Entry k (k = 0 for the first angle) sits at bits [k*ANG_W +: ANG_W] of `angles_i`, with ANG_W = PHASE_W−1. For a phase h in [0, π/2), `leg_o` is 1 exactly when the number of angles ≤ h is even. The leg therefore starts high and toggles at each angle.
- R4: For h in [π/2, π), each angle a also places a transition at π−a. `leg_o` is 1 exactly when the total count of transitions at or before h is even, where the count includes all N first-quarter angles.
- R5: For a phase in [π, 2π), `leg_o` is the inverse of the value it would have at the phase minus π.
- R6: After the first edge following reset, `gate_hi_o` equals `leg_o` and `gate_lo_o` equals its inverse. The two gates are never 1 together.
- R7: A change of `angles_i` has no effect on the outputs until the accumulator wraps. The table is captured only on the edge where the phase carries past 2π, or on the first edge after reset.
- R8: A captured table whose angles are not strictly increasing, or which has any angle ≥ 2^(PHASE_W−2), sets `err_o` to 1 for that period. During that period `leg_o` is 1 for the first half and 0 for the second half. Capturing a valid table clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_inc_i | input | PHASE_W | Phase step added each clock |
| angles_i | input | N_ANG*(PHASE_W-1) | Packed first-quarter switching angles |
| leg_o | output | 1 | Leg command, 1 = positive rail |
| gate_hi_o | output | 1 | Upper switch enable |
| gate_lo_o | output | 1 | Lower switch enable |
| err_o | output | 1 | Active table rejected, square wave in use |

## Verification
The bench targets the reflected second-quarter edges, where an off-by-one in the π/2 mirror would shift every later transition by one phase step. It also covers a first angle of zero and an angle at π/2−1, which would move the toggle across a quarter or half boundary. A table changed mid-period is checked against the old pattern until the next wrap; a design that captures early would chop with the new angles straight away. Duplicate angles and an angle at π/2 must produce the plain square wave and the flag. An increment that does not divide the period checks that the wrap is taken from the carry and not from phase zero.

// File: rtl/she_pkg.sv
package she_pkg;

  typedef enum logic [1:0] {
    QTR_RISE     = 2'd0,
    QTR_FALL     = 2'd1,
    QTR_NEG_RISE = 2'd2,
    QTR_NEG_FALL = 2'd3
  } quarter_e;

  typedef struct packed {
    logic leg;
    logic hi;
    logic lo;
  } drive_t;

endpackage

// File: rtl/she_phase_acc.sv
module she_phase_acc #(
  parameter int PHASE_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] inc_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               wrap_o,
  output logic               load_o,
  output logic               primed_o
);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W:0]   sum;
  logic               primed_q;

  assign sum    = {1'b0, phase_q} + {1'b0, inc_i};
  assign wrap_o = sum[PHASE_W];
  // first edge after reset also captures a table
  assign load_o = wrap_o | ~primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= '0;
      primed_q <= 1'b0;
    end else begin
      phase_q  <= sum[PHASE_W-1:0];
      primed_q <= 1'b1;
    end
  end

  assign phase_o  = phase_q;
  assign primed_o = primed_q;

endmodule

// File: rtl/she_table_reg.sv
module she_table_reg #(
  parameter int N_ANG   = 4,
  parameter int PHASE_W = 12,
  parameter int ANG_W   = PHASE_W - 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [N_ANG*ANG_W-1:0] tab_i,
  output logic [N_ANG*ANG_W-1:0] tab_o,
  output logic                   err_o
);

  localparam int QW = PHASE_W - 2;
  localparam logic [ANG_W-1:0] QTR_LIM = ANG_W'(1) << QW;

  logic [N_ANG-1:0] ok_lim;
  logic [N_ANG-1:0] ok_ord;
  logic             tab_ok;

  for (genvar k = 0; k < N_ANG; k++) begin : g_chk
    logic [ANG_W-1:0] cur;
    assign cur       = tab_i[k*ANG_W +: ANG_W];
    assign ok_lim[k] = cur < QTR_LIM;
    if (k == 0) begin : g_first
      assign ok_ord[k] = 1'b1;
    end else begin : g_rest
      assign ok_ord[k] = cur > tab_i[(k-1)*ANG_W +: ANG_W];
    end
  end

  assign tab_ok = &ok_lim & &ok_ord;

  logic [N_ANG*ANG_W-1:0] tab_q;
  logic                   err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tab_q <= '0;
      err_q <= 1'b0;
    end else if (load_i) begin
      tab_q <= tab_i;
      err_q <= ~tab_ok;
    end
  end

  assign tab_o = tab_q;
  assign err_o = err_q;

endmodule

// File: rtl/she_level.sv
module she_level
  import she_pkg::*;
#(
  parameter int N_ANG   = 4,
  parameter int PHASE_W = 12,
  parameter int ANG_W   = PHASE_W - 1
) (
  input  logic [PHASE_W-1:0]     phase_i,
  input  logic [N_ANG*ANG_W-1:0] tab_i,
  input  logic                   err_i,
  output logic                   level_o
);

  localparam int QW = PHASE_W - 2;
  localparam logic [ANG_W:0] QTR_SUM = (ANG_W+1)'(1) << QW;
  localparam logic N_ODD = (N_ANG % 2) == 1;

  logic [QW-1:0]    pos;
  quarter_e         qtr;
  logic             neg_half;
  logic [N_ANG-1:0] hit_rise;
  logic [N_ANG-1:0] hit_fall;
  logic             pos_lvl;

  assign pos      = phase_i[QW-1:0];
  assign qtr      = quarter_e'(phase_i[PHASE_W-1 -: 2]);
  assign neg_half = phase_i[PHASE_W-1];

  for (genvar k = 0; k < N_ANG; k++) begin : g_cmp
    logic [ANG_W-1:0] ang;
    logic [ANG_W:0]   mir;
    assign ang         = tab_i[k*ANG_W +: ANG_W];
    assign hit_rise[k] = ang <= {1'b0, pos};
    // pi - a <= pi/2 + pos  <=>  a + pos >= pi/2
    assign mir         = {1'b0, ang} + {2'b0, pos};
    assign hit_fall[k] = mir >= QTR_SUM;
  end

  always_comb begin
    unique case (qtr)
      QTR_RISE, QTR_NEG_RISE: pos_lvl = ~^hit_rise;
      default:                pos_lvl = ~(^hit_fall ^ N_ODD);
    endcase
    level_o = err_i ? ~neg_half : (pos_lvl ^ neg_half);
  end

endmodule

// File: rtl/she_gate_out.sv
module she_gate_out
  import she_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic primed_i,
  input  logic level_i,
  output logic leg_o,
  output logic gate_hi_o,
  output logic gate_lo_o
);

  drive_t drv_d, drv_q;

  always_comb begin
    drv_d.leg = primed_i & level_i;
    drv_d.hi  = primed_i & level_i;
    drv_d.lo  = primed_i & ~level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= '0;
    else         drv_q <= drv_d;
  end

  assign leg_o     = drv_q.leg;
  assign gate_hi_o = drv_q.hi;
  assign gate_lo_o = drv_q.lo;

endmodule

// File: rtl/she_pattern_gen.sv
module she_pattern_gen #(
  parameter int N_ANG   = 4,
  parameter int PHASE_W = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [PHASE_W-1:0]           phase_inc_i,
  input  logic [N_ANG*(PHASE_W-1)-1:0] angles_i,
  output logic                         leg_o,
  output logic                         gate_hi_o,
  output logic                         gate_lo_o,
  output logic                         err_o
);

  localparam int ANG_W = PHASE_W - 1;

  logic [PHASE_W-1:0]     phase_q;
  logic                   wrap;
  logic                   load;
  logic                   primed_q;
  logic [N_ANG*ANG_W-1:0] tab_act;
  logic                   err_q;
  logic                   level;

  she_phase_acc #(
    .PHASE_W (PHASE_W)
  ) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (phase_inc_i),
    .phase_o  (phase_q),
    .wrap_o   (wrap),
    .load_o   (load),
    .primed_o (primed_q)
  );

  she_table_reg #(
    .N_ANG   (N_ANG),
    .PHASE_W (PHASE_W),
    .ANG_W   (ANG_W)
  ) u_tab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .tab_i  (angles_i),
    .tab_o  (tab_act),
    .err_o  (err_q)
  );

  she_level #(
    .N_ANG   (N_ANG),
    .PHASE_W (PHASE_W),
    .ANG_W   (ANG_W)
  ) u_lvl (
    .phase_i (phase_q),
    .tab_i   (tab_act),
    .err_i   (err_q),
    .level_o (level)
  );

  she_gate_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .primed_i  (primed_q),
    .level_i   (level),
    .leg_o     (leg_o),
    .gate_hi_o (gate_hi_o),
    .gate_lo_o (gate_lo_o)
  );

  assign err_o = err_q;

endmodule

// File: rtl/she_pattern_gen_chk.sv
module she_pattern_gen_chk #(
  parameter int PHASE_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PHASE_W-1:0] phase_inc_i,
  input logic               leg_o,
  input logic               gate_hi_o,
  input logic               gate_lo_o,
  input logic               err_o,
  input logic [PHASE_W-1:0] phase_q,
  input logic               primed_q,
  input logic               wrap
);

  AST_QUIET_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(primed_q) |-> (!leg_o && !gate_hi_o && !gate_lo_o)); // R1

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(primed_q) |-> phase_q == PHASE_W'($past(phase_q) + $past(phase_inc_i))); // R2

  AST_GATE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hi_o && gate_lo_o)); // R6

  AST_GATE_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(primed_q) |-> (gate_hi_o == leg_o && gate_lo_o != leg_o)); // R6

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(primed_q) && !$past(wrap)) |-> $stable(err_o)); // R7

  AST_ERR_SQUARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(primed_q) && $past(err_o)) |-> leg_o == !$past(phase_q[PHASE_W-1])); // R8

endmodule

bind she_pattern_gen she_pattern_gen_chk #(
  .PHASE_W (PHASE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_inc_i (phase_inc_i),
  .leg_o       (leg_o),
  .gate_hi_o   (gate_hi_o),
  .gate_lo_o   (gate_lo_o),
  .err_o       (err_o),
  .phase_q     (phase_q),
  .primed_q    (primed_q),
  .wrap        (wrap)
);

// File: tb/she_pattern_gen_bench.sv
module she_pattern_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int PW   = 12;
  localparam int AW   = PW - 1;
  localparam int FULL = 1 << PW;
  localparam int HALF = FULL / 2;
  localparam int QTR  = FULL / 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PW-1:0]   inc = '0;
  logic [N*AW-1:0] tab = '0;
  logic            leg_o, gate_hi_o, gate_lo_o, err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  she_pattern_gen #(.N_ANG(N), .PHASE_W(PW)) u_she_pattern_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .phase_inc_i (inc),
    .angles_i    (tab),
    .leg_o       (leg_o),
    .gate_hi_o   (gate_hi_o),
    .gate_lo_o   (gate_lo_o),
    .err_o       (err_o)
  );

  int checks = 0;
  int failures = 0;

  int    nxt_inc;
  int    nxt_ang[N];
  int    m_phase = 0;
  int    m_ang[N];
  bit    m_err = 0;
  bit    m_primed = 0;
  bit    pend_r7 = 0;
  string force_tag = "";

  logic [3:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [N*AW-1:0] pack_tab(input int a[N]);
    logic [N*AW-1:0] r = '0;
    for (int k = 0; k < N; k++) r[k*AW +: AW] = AW'(a[k]);
    return r;
  endfunction

  function automatic bit tab_ok(input int a[N]);
    for (int k = 0; k < N; k++) begin
      if (a[k] >= QTR) return 0;
      if (k > 0 && a[k] <= a[k-1]) return 0;
    end
    return 1;
  endfunction

  // transition list: a_k and pi - a_k inside the positive half
  function automatic bit exp_level(input int ph, input int a[N], input bit e);
    int  h = ph % HALF;
    bit  neg = ph >= HALF;
    int  cnt = 0;
    bit  lvl;
    if (e) return !neg;
    for (int k = 0; k < N; k++) begin
      if (a[k] <= h) cnt++;
      if (HALF - a[k] <= h) cnt++;
    end
    lvl = (cnt % 2) == 0;
    return neg ? !lvl : lvl;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // driver: apply inputs, predict the outputs of the coming edge
  task automatic step();
    bit    load, lvl, chg;
    string t;
    logic [3:0] e;
    inc = PW'(nxt_inc);
    tab = pack_tab(nxt_ang);
    load = !m_primed || (m_phase + nxt_inc >= FULL);
    chg = 0;
    for (int k = 0; k < N; k++) if (nxt_ang[k] != m_ang[k]) chg = 1;
    if (!m_primed)           t = "R1";
    else if (m_err)          t = "R8";
    else if (pend_r7)        t = "R7";
    else if (force_tag != "") t = force_tag;
    else if (m_phase < QTR)  t = "R3";
    else if (m_phase < HALF) t = "R4";
    else                     t = "R5";
    lvl = m_primed ? exp_level(m_phase, m_ang, m_err) : 1'b0;
    if (load) begin
      for (int k = 0; k < N; k++) m_ang[k] = nxt_ang[k];
      m_err = !tab_ok(nxt_ang);
      pend_r7 = 0;
    end else if (chg) begin
      pend_r7 = 1;
    end
    if (!m_primed) e = {3'b000, m_err};
    else           e = {lvl, lvl, !lvl, m_err};
    exp_q.push_back(e);
    tag_q.push_back(t);
    m_phase = (m_phase + nxt_inc) % FULL;
    m_primed = 1;
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      step();
    end
  endtask

  task automatic set_tab(input int a0, input int a1, input int a2, input int a3);
    nxt_ang[0] = a0; nxt_ang[1] = a1; nxt_ang[2] = a2; nxt_ang[3] = a3;
  endtask

  // monitor
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(leg_o === e[3], t, int'(leg_o), int'(e[3]), "leg");
      check(gate_hi_o === e[2] && gate_lo_o === e[1], (t == "R1") ? "R1" : "R6",
            int'({gate_hi_o, gate_lo_o}), int'(e[2:1]), "gates");
      check(!(gate_hi_o && gate_lo_o), "R6", int'({gate_hi_o, gate_lo_o}), 0, "overlap");
      check(err_o === e[0], "R8", int'(err_o), int'(e[0]), "err");
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int k = 0; k < N; k++) m_ang[k] = 0;
    nxt_inc = 16;
    set_tab(100, 300, 500, 900);
    repeat (3) @(negedge clk);
    check(leg_o === 1'b0, "R1", int'(leg_o), 0, "reset leg");
    check(gate_hi_o === 1'b0, "R1", int'(gate_hi_o), 0, "reset hi");
    check(gate_lo_o === 1'b0, "R1", int'(gate_lo_o), 0, "reset lo");
    check(err_o === 1'b0, "R1", int'(err_o), 0, "reset err");
    @(negedge clk);
    rst_n = 1'b1;
    step();
    run(600);
    // R7: new valid table mid-period, must wait for the wrap
    set_tab(50, 200, 700, 1000);
    run(400);
    // R8: duplicate angles
    set_tab(100, 300, 300, 900);
    run(400);
    // R8: angle at pi/2
    set_tab(100, 300, 500, 1024);
    run(300);
    // R3/R4 corner: first angle zero, last angle one below pi/2
    set_tab(0, 256, 512, 1023);
    run(300);
    // R2: increment that does not divide the period
    set_tab(100, 300, 500, 900);
    force_tag = "R2";
    nxt_inc = 7;
    run(1300);
    nxt_inc = 300;
    run(100);
    force_tag = "";
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule